// File: doc/BRIEF.md
# Watchdog Timer with Register Port

This block is a watchdog for a system controller. Software programs a timeout as a power-of-two index, picks where an expiry goes, and then arms the timer through a control register. Once armed, the timer counts pulses on `tick_en`, which stand in for a one-second time base scaled down by `TICKS_PER_SEC`. If software does not restart the count before the chosen number of seconds has passed, the block raises an interrupt. It can also raise a one-cycle system reset, depending on the routing field.

Every restart goes through a short handshake. Writing the restart bit drops the running flag in the control register. The flag returns to 1 only once the count has really started again from zero, and software polls it before going on. Turning the timer off also drops the flag, so software can tell an idle timer from a running one before it programs a new period.

The register port is a plain single-cycle write strobe with an address and data. Read data is combinational on the address.

Top module: `wdog_timer`

## Requirements
- R1: Three registers are decoded at byte addresses 0x3004, 0x3008 and 0x300C; any other address reads 0. 0x3004 holds a 4-bit period code in bits [3:0] and reads back as written, with reset value 9. 0x3008 holds a 2-bit routing field in bits [1:0] with reset value 0. 0x300C has the enable bit at bit 0 (read/write, reset 0), a write-only restart bit at bit 1 that always reads 0, and a read-only running flag at bit 8.
- R2: A start happens when a write to 0x300C sets bit 0 and either bit 1 is set or the timer was off. At the edge that takes the write, the running flag goes to 0. It becomes 1 after the second following edge (HS_CYCLES = 2).
- R3: While the running flag is 1, each cycle with `tick_en` high counts. The interrupt rises at the edge of the counted tick number TICKS_PER_SEC × 2^(code−3). It stays low before that tick.
- R4: Period codes below 3 act as 3 (1 s) and codes above 10 act as 10 (128 s).
- R5: Once set, `irq` stays high until the next start or the timer is turned off. It holds even while no ticks arrive.
- R6: With routing value 0, an expiry also drives `sys_rst` high for exactly one cycle, in the same cycle that `irq` first goes high. Values 1, 2 and 3 raise `irq` alone.
- R7: Writing 0 to bit 0 of 0x300C while the timer is on turns it off. After that write edge the running flag and `irq` are 0, and no ticks are counted while the timer is off.
- R8: A write of 0x3 to 0x300C while the timer is on restarts the count from zero and clears `irq`. Ticks seen before the restart do not count toward the next expiry.
- R9: A period code written while the timer is on takes effect only at the next start. The expiry in progress uses the code that was latched at its own start.
- R10: Writing the restart bit with the enable bit clear while the timer is off has no effect. The control register keeps reading 0 and no count starts.
- R11: Ticks that arrive during the restart handshake, while the running flag is 0, are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Scaled time-base pulse, one count per high cycle |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Sticky expiry interrupt |
| sys_rst | output | 1 | One-cycle system reset request on expiry |

## Verification
Read data follows the address in the same cycle, so the bench samples it 1 ns after changing the address, well away from a clock edge. After a start write, the running flag is due 0 right after the write edge and 1 two edges later, and the bench reads it at the negative edge after each of those edges. `irq` and `sys_rst` are due right after the edge of the final counted tick. The bench therefore drives exactly one tick fewer than the expected count, checks that `irq` is still low, then drives one more tick and checks it high. It checks `sys_rst` again one cycle later to confirm the pulse has ended. Ticks are driven at negative edges, so every counted edge is known exactly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [15:0] OFS_PERIOD = 16'h3004;
  localparam logic [15:0] OFS_ROUTE  = 16'h3008;
  localparam logic [15:0] OFS_CTRL   = 16'h300C;

  localparam int CODE_W = 4;
  localparam int SEC_W  = 8;

  localparam logic [CODE_W-1:0] CODE_MIN   = 4'd3;
  localparam logic [CODE_W-1:0] CODE_MAX   = 4'd10;
  localparam logic [CODE_W-1:0] CODE_RESET = 4'd9;

  localparam int BIT_EN   = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_STAT = 8;

  typedef enum logic [1:0] {
    ROUTE_BOTH = 2'd0,
    ROUTE_RSV1 = 2'd1,
    ROUTE_IRQ  = 2'd2,
    ROUTE_RSV3 = 2'd3
  } route_e;

  typedef struct packed {
    logic start;
    logic stop;
  } cmd_t;

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
    if (c < CODE_MIN) return CODE_MIN;
    if (c > CODE_MAX) return CODE_MAX;
    return c;
  endfunction

  function automatic logic [SEC_W-1:0] code_to_secs(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] sh;
    sh = clamp_code(c) - CODE_MIN;
    return 8'd1 << sh;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              status,
  output logic [CODE_W-1:0] period_code,
  output route_e            route,
  output logic              enable,
  output cmd_t              cmd,
  output logic [DATA_W-1:0] bus_rdata
);

  logic [CODE_W-1:0] code_q, code_d;
  route_e            route_q, route_d;
  logic              en_q, en_d;
  logic              sel_period, sel_route, sel_ctrl;
  logic              wr_ctrl;
  logic              unused_wdata;

  assign sel_period   = (bus_addr == ADDR_W'(OFS_PERIOD));
  assign sel_route    = (bus_addr == ADDR_W'(OFS_ROUTE));
  assign sel_ctrl     = (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_ctrl      = bus_wr && sel_ctrl;
  assign unused_wdata = ^bus_wdata[DATA_W-1:CODE_W];

  always_comb begin
    code_d  = code_q;
    route_d = route_q;
    en_d    = en_q;
    if (bus_wr && sel_period) code_d  = bus_wdata[CODE_W-1:0];
    if (bus_wr && sel_route)  route_d = route_e'(bus_wdata[1:0]);
    if (wr_ctrl)              en_d    = bus_wdata[BIT_EN];
  end

  always_comb begin
    cmd.start = wr_ctrl && bus_wdata[BIT_EN] && (bus_wdata[BIT_CLR] || !en_q);
    cmd.stop  = wr_ctrl && !bus_wdata[BIT_EN] && en_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_period) begin
      bus_rdata[CODE_W-1:0] = code_q;
    end else if (sel_route) begin
      bus_rdata[1:0] = route_q;
    end else if (sel_ctrl) begin
      bus_rdata[BIT_EN]   = en_q;
      bus_rdata[BIT_STAT] = status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= CODE_RESET;
      route_q <= ROUTE_BOTH;
      en_q    <= 1'b0;
    end else begin
      code_q  <= code_d;
      route_q <= route_d;
      en_q    <= en_d;
    end
  end

  assign period_code = code_q;
  assign route       = route_q;
  assign enable      = en_q;

endmodule

// File: rtl/wdog_handshake.sv
module wdog_handshake
  import wdog_pkg::*;
#(
  parameter int HS_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  output logic status
);

  localparam int CW = (HS_CYCLES > 1) ? $clog2(HS_CYCLES + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          st_q, st_d;

  always_comb begin
    cnt_d = cnt_q;
    st_d  = st_q;
    if (cmd.start) begin
      cnt_d = CW'(HS_CYCLES);
      st_d  = 1'b0;
    end else if (cmd.stop) begin
      cnt_d = '0;
      st_d  = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) st_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      st_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

  assign status = st_q;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic              run,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] code,
  output logic              expire
);

  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [SEC_W-1:0] lim_q, lim_d;
  logic [SEC_W-1:0] sec_inc;
  logic             done_q, done_d;
  logic             step;

  assign step    = run && !done_q && tick_en;
  assign sec_inc = sec_q + 8'd1;

  always_comb begin
    pre_d  = pre_q;
    sec_d  = sec_q;
    lim_d  = lim_q;
    done_d = done_q;
    expire = 1'b0;
    if (cmd.start) begin
      pre_d  = '0;
      sec_d  = '0;
      done_d = 1'b0;
      lim_d  = code_to_secs(code);
    end else if (cmd.stop) begin
      pre_d  = '0;
      sec_d  = '0;
      done_d = 1'b0;
    end else if (step) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        if (sec_inc == lim_q) begin
          sec_d  = '0;
          done_d = 1'b1;
          expire = 1'b1;
        end else begin
          sec_d = sec_inc;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sec_q  <= '0;
      lim_q  <= '0;
      done_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      sec_q  <= sec_d;
      lim_q  <= lim_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm
  import wdog_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cmd_t   cmd,
  input  logic   expire,
  input  route_e route,
  output logic   irq,
  output logic   sys_rst
);

  logic irq_q, irq_d;
  logic rst_q, rst_d;

  always_comb begin
    irq_d = irq_q;
    rst_d = 1'b0;
    if (cmd.start || cmd.stop) begin
      irq_d = 1'b0;
    end else if (expire) begin
      irq_d = 1'b1;
      rst_d = (route == ROUTE_BOTH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end

  assign irq     = irq_q;
  assign sys_rst = rst_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 32,
  parameter int TICKS_PER_SEC = 4,
  parameter int HS_CYCLES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_rst
);

  logic [CODE_W-1:0] code_w;
  route_e            route_w;
  logic              en_w;
  cmd_t              cmd_w;
  logic              status_w;
  logic              expire_w;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .status     (status_w),
    .period_code(code_w),
    .route      (route_w),
    .enable     (en_w),
    .cmd        (cmd_w),
    .bus_rdata  (bus_rdata)
  );

  wdog_handshake #(.HS_CYCLES(HS_CYCLES)) u_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd_w),
    .status(status_w)
  );

  wdog_counter #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd_w),
    .run    (status_w),
    .tick_en(tick_en),
    .code   (code_w),
    .expire (expire_w)
  );

  wdog_alarm u_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd_w),
    .expire (expire_w),
    .route  (route_w),
    .irq    (irq),
    .sys_rst(sys_rst)
  );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic status,
  input logic irq,
  input logic sys_rst,
  input logic start_p,
  input logic stop_p
);

  // R6
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);

  // R6
  rst_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> irq);

  // R7
  off_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !status);

  // R2
  hs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !status);

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !start_p && !stop_p) |=> irq);

  // R3
  irq_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(status));

endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (en_w),
  .status (status_w),
  .irq    (irq),
  .sys_rst(sys_rst),
  .start_p(cmd_w.start),
  .stop_p (cmd_w.stop)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

  localparam int TPS = 4;
  localparam logic [15:0] A_PER  = 16'h3004;
  localparam logic [15:0] A_RTE  = 16'h3008;
  localparam logic [15:0] A_CTL  = 16'h300C;
  localparam logic [15:0] A_NONE = 16'h3010;

  // {code[3:0], route[1:0]}
  localparam logic [5:0] VEC [6] = '{
    {4'd3,  2'd0}, {4'd4, 2'd2}, {4'd0, 2'd0},
    {4'd15, 2'd2}, {4'd5, 2'd1}, {4'd6, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        sys_rst;
  logic [31:0] rv;
  int          errors = 0;
  int          checks = 0;
  bit          done   = 1'b0;

  always #10 clk = ~clk;

  wdog_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sys_rst(sys_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  function automatic int ticks_for(input int code);
    int c = code;
    if (c < 3) c = 3;
    if (c > 10) c = 10;
    return TPS * (1 << (c - 3));
  endfunction

  task automatic wait_hs(input string req);
    rd(A_CTL, rv); check({req, " status low after start"}, 32'(rv[8]), 32'd0);
    @(negedge clk);
    rd(A_CTL, rv); check({req, " status low mid handshake"}, 32'(rv[8]), 32'd0);
    @(negedge clk);
    rd(A_CTL, rv); check({req, " status high after handshake"}, 32'(rv[8]), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and map
    rd(A_PER, rv);  check("R1 period reset", rv, 32'd9);
    rd(A_RTE, rv);  check("R1 route reset", rv, 32'd0);
    rd(A_CTL, rv);  check("R1 ctrl reset", rv, 32'd0);
    rd(A_NONE, rv); check("R1 unmapped", rv, 32'd0);
    check("R1 irq reset", 32'(irq), 32'd0);
    check("R1 sys_rst reset", 32'(sys_rst), 32'd0);

    // R10 restart bit while off, R7 no counting while off
    wr(A_PER, 32'd3);
    wr(A_CTL, 32'h2);
    rd(A_CTL, rv); check("R10 ctrl after clear while off", rv, 32'd0);
    ticks(20);
    check("R7 no irq while off", 32'(irq), 32'd0);

    // Vector table: R3 R4 R6 R5 R7
    foreach (VEC[i]) begin
      int code = int'(VEC[i][5:2]);
      int sel  = int'(VEC[i][1:0]);
      int n    = ticks_for(code);
      wr(A_PER, 32'(code));
      wr(A_RTE, 32'(sel));
      rd(A_PER, rv); check("R1 period readback", rv, 32'(code));
      wr(A_CTL, 32'h3);
      wait_hs("R2");
      ticks(n - 1);
      check("R3 R4 irq low before last tick", 32'(irq), 32'd0);
      ticks(1);
      check("R3 R4 irq at last tick", 32'(irq), 32'd1);
      check("R6 sys_rst with irq", 32'(sys_rst), (sel == 0) ? 32'd1 : 32'd0);
      @(negedge clk);
      check("R6 sys_rst one cycle", 32'(sys_rst), 32'd0);
      repeat (3) @(negedge clk);
      check("R5 irq sticky", 32'(irq), 32'd1);
      wr(A_CTL, 32'h0);
      check("R7 irq off", 32'(irq), 32'd0);
      rd(A_CTL, rv); check("R7 ctrl off", rv, 32'd0);
    end

    // R8 restart mid count
    wr(A_PER, 32'd3); wr(A_RTE, 32'd2);
    wr(A_CTL, 32'h3); wait_hs("R2");
    ticks(3);
    wr(A_CTL, 32'h3); wait_hs("R8");
    ticks(3);
    check("R8 count restarted", 32'(irq), 32'd0);
    ticks(1);
    check("R8 expiry after restart", 32'(irq), 32'd1);
    wr(A_CTL, 32'h3);
    check("R8 R5 restart clears irq", 32'(irq), 32'd0);
    @(negedge clk); @(negedge clk);

    // R9 period write while on
    wr(A_PER, 32'd5);
    ticks(3);
    check("R9 old period not yet", 32'(irq), 32'd0);
    ticks(1);
    check("R9 old period used", 32'(irq), 32'd1);

    // R11 ticks during handshake ignored; new period active
    tick_en = 1'b1;
    wr(A_CTL, 32'h3);
    @(negedge clk); @(negedge clk);
    rd(A_CTL, rv); check("R2 status high with ticks", 32'(rv[8]), 32'd1);
    repeat (15) @(negedge clk);
    check("R11 R9 irq low at 15", 32'(irq), 32'd0);
    @(negedge clk);
    check("R11 R9 irq at 16", 32'(irq), 32'd1);
    tick_en = 1'b0;

    // R2 start by enable alone
    wr(A_CTL, 32'h0);
    wr(A_CTL, 32'h1);
    wait_hs("R2 enable only");
    rd(A_CTL, rv); check("R1 clear bit reads 0", rv, 32'h101);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule